// File: doc/BRIEF.md
# Fuse Latch and Lock Controller

This block keeps three 8-bit configuration bytes (extended, high and low) and one 8-bit lock byte in a register model of non-volatile storage. Next to them it keeps a working copy of the configuration bytes. The rest of the chip uses only this working copy. The copy is refreshed from storage at two moments: when the chip powers up in normal mode, and when programming mode is entered. A write to storage therefore has no visible effect until the next refresh. The one exception is the EEPROM-preserve bit, which follows each accepted write at once.

The lock byte controls two things. Its guard bit blocks any further writes to the configuration bytes. Its boot pair sets whether self-programming may write the boot section, and whether code in the application section may read the boot section. A chip erase returns every lock bit to the unprogrammed state and leaves the configuration bytes as they are. When application code is denied reads of the boot section, the interrupt vectors sit in the application section, and code is running from the boot section, the block raises an interrupt mask.

Top module: `fuse_lock_ctrl`

## Requirements
- R1: While `rst_n` is low, all three working bytes and `lock_bits` read 0xFF. On the first clock edge after release with `prog_mode` low, the working bytes load the stored values, which after reset are extended 0xFF, high 0x99 and low 0x62.
- R2: A bit reads 0 when programmed and 1 when unprogrammed. `fuse_sel` picks the stored byte for a write: 0 selects low, 1 selects high, 2 selects extended. A write with `fuse_sel` equal to 3 changes nothing.
- R3: On the clock edge where `prog_mode` is first sampled high, all working bytes load from storage.
- R4: A stored change becomes visible in the working bytes only at the next load. Writes made in normal mode or in programming mode do not change the working bytes before then, and leaving programming mode does not trigger a load.
- R5: On an accepted write to the high byte, working high bit 3 (EEPROM preserve) takes the written value on that same clock edge. The other working bits keep their values.
- R6: A `chip_erase` pulse sets `lock_bits` to 0xFF on the next edge and changes no stored configuration bit.
- R7: While `lock_bits` bit 0 is 0, configuration writes are ignored. This includes the immediate update of the EEPROM-preserve bit.
- R8: A lock write ANDs `lock_wdata` into `lock_bits`, so a lock bit can go from 1 to 0 but never from 0 to 1. `chip_erase` takes priority over a lock write in the same cycle.
- R9: The boot pair is `lock_bits[5:4]`. The outputs decode it as follows: 11 gives no restriction; 10 denies boot writes only; 00 denies boot writes and application reads of the boot section; 01 denies application reads only.
- R10: `irq_mask` is high exactly when application reads of the boot section are denied, `ivec_in_app` is high and `exec_in_boot` is high.
- R11: A configuration write in the same cycle as a load goes to storage only. The load takes the value stored before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, active low |
| prog_mode | input | 1 | High while in programming mode |
| fuse_wr | input | 1 | Configuration byte write strobe |
| fuse_sel | input | 2 | Byte select: 0 low, 1 high, 2 extended |
| fuse_wdata | input | 8 | Configuration write data |
| lock_wr | input | 1 | Lock byte write strobe |
| lock_wdata | input | 8 | Lock write data, ANDed into storage |
| chip_erase | input | 1 | Chip erase pulse |
| ivec_in_app | input | 1 | Interrupt vectors located in application section |
| exec_in_boot | input | 1 | Code currently running from boot section |
| act_ext | output | 8 | Working extended byte |
| act_high | output | 8 | Working high byte |
| act_low | output | 8 | Working low byte |
| lock_bits | output | 8 | Stored lock byte |
| boot_wr_deny | output | 1 | Self-programming writes to boot section denied |
| app_rd_deny | output | 1 | Application-section reads of boot section denied |
| irq_mask | output | 1 | Interrupts masked |

## Verification
The assertions assume that every strobe is synchronous to `clk` and that `prog_mode` is a level that stays stable for whole cycles. They also assume the reset value of storage is the factory state, so the lock byte never starts below 0xFF.

The bench changes inputs only on falling edges and holds each strobe for exactly one cycle. It moves in and out of programming mode one cycle at a time, so every load edge is known in advance. The only overlapping strobes it drives are the ones the requirements define: a write together with a load, and an erase together with a lock write.

// File: rtl/fuse_lock_ctrl.sv
module fuse_lock_ctrl #(
  parameter logic [7:0] EXT_DEF   = 8'hFF,
  parameter logic [7:0] HIGH_DEF  = 8'h99,
  parameter logic [7:0] LOW_DEF   = 8'h62,
  parameter int         EESAVE_BIT = 3,
  parameter int         GUARD_BIT  = 0,
  parameter int         BOOT_LO    = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_mode,
  input  logic       fuse_wr,
  input  logic [1:0] fuse_sel,
  input  logic [7:0] fuse_wdata,
  input  logic       lock_wr,
  input  logic [7:0] lock_wdata,
  input  logic       chip_erase,
  input  logic       ivec_in_app,
  input  logic       exec_in_boot,
  output logic [7:0] act_ext,
  output logic [7:0] act_high,
  output logic [7:0] act_low,
  output logic [7:0] lock_bits,
  output logic       boot_wr_deny,
  output logic       app_rd_deny,
  output logic       irq_mask
);
  localparam int BOOT_HI = BOOT_LO + 1;

  logic [7:0] nv_ext, nv_high, nv_low, lock_q;
  logic       prog_q, pend;

  wire wr_ok   = fuse_wr & lock_q[GUARD_BIT];
  wire wr_low  = wr_ok & (fuse_sel == 2'd0);
  wire wr_high = wr_ok & (fuse_sel == 2'd1);
  wire wr_ext  = wr_ok & (fuse_sel == 2'd2);
  wire load    = pend | (prog_mode & ~prog_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_ext   <= EXT_DEF;
      nv_high  <= HIGH_DEF;
      nv_low   <= LOW_DEF;
      lock_q   <= 8'hFF;
      act_ext  <= 8'hFF;
      act_high <= 8'hFF;
      act_low  <= 8'hFF;
      prog_q   <= 1'b0;
      pend     <= 1'b1;
    end else begin
      prog_q <= prog_mode;
      pend   <= 1'b0;
      if (load) begin
        act_ext  <= nv_ext;
        act_high <= nv_high;
        act_low  <= nv_low;
      end
      if (wr_high) act_high[EESAVE_BIT] <= fuse_wdata[EESAVE_BIT];
      if (wr_low)  nv_low  <= fuse_wdata;
      if (wr_high) nv_high <= fuse_wdata;
      if (wr_ext)  nv_ext  <= fuse_wdata;
      if (chip_erase)   lock_q <= 8'hFF;
      else if (lock_wr) lock_q <= lock_q & lock_wdata;
    end
  end

  assign lock_bits    = lock_q;
  assign boot_wr_deny = ~lock_q[BOOT_LO];
  assign app_rd_deny  = ~lock_q[BOOT_HI];
  assign irq_mask     = app_rd_deny & ivec_in_app & exec_in_boot;

  // R7
  guarded_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_wr && !lock_q[GUARD_BIT]) |=> ($stable(nv_ext) && $stable(nv_high) && $stable(nv_low)));

  // R6
  erase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chip_erase |=> (lock_bits == 8'hFF && $stable(nv_ext) && $stable(nv_high) && $stable(nv_low)));

  // R8
  lock_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !chip_erase |=> ((lock_bits & ~$past(lock_bits)) == 8'h00));

  // R4
  hold_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pend && !(prog_mode && !prog_q) && !wr_high) |=> ($stable(act_ext) && $stable(act_high) && $stable(act_low)));

  // R5
  eesave_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_high |=> (act_high[EESAVE_BIT] == $past(fuse_wdata[EESAVE_BIT])));

  // R10
  irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_mask |-> (app_rd_deny && exec_in_boot));
endmodule

// File: tb/test_fuse_lock_ctrl.sv
module test_fuse_lock_ctrl;
  localparam time CLK_PERIOD = 10ns;

  logic clk = 1'b0, rst_n = 1'b0, prog_mode = 1'b0;
  logic fuse_wr = 1'b0, lock_wr = 1'b0, chip_erase = 1'b0;
  logic ivec_in_app = 1'b0, exec_in_boot = 1'b0;
  logic [1:0] fuse_sel = 2'd0;
  logic [7:0] fuse_wdata = 8'h00, lock_wdata = 8'hFF;
  logic [7:0] act_ext, act_high, act_low, lock_bits;
  logic boot_wr_deny, app_rd_deny, irq_mask;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fuse_lock_ctrl i_fuse_lock_ctrl (.*);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_act(string req, logic [7:0] e, logic [7:0] h, logic [7:0] l);
    chk(req, act_ext, e);
    chk(req, act_high, h);
    chk(req, act_low, l);
  endtask

  task automatic fwrite(logic [1:0] sel, logic [7:0] d);
    fuse_wr = 1'b1; fuse_sel = sel; fuse_wdata = d;
    @(negedge clk);
    fuse_wr = 1'b0;
  endtask

  task automatic lwrite(logic [7:0] d);
    lock_wr = 1'b1; lock_wdata = d;
    @(negedge clk);
    lock_wr = 1'b0; lock_wdata = 8'hFF;
  endtask

  task automatic reenter();
    prog_mode = 1'b0;
    @(negedge clk);
    prog_mode = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset();
    repeat (2) @(negedge clk);
    chk_act("R1 in reset", 8'hFF, 8'hFF, 8'hFF);
    chk("R1 lock in reset", lock_bits, 8'hFF);
    rst_n = 1'b1;
    @(negedge clk);
    chk_act("R1 power-up load", 8'hFF, 8'h99, 8'h62);
  endtask

  task automatic t_capture();
    fwrite(2'd0, 8'h3C);
    chk("R4 normal write hidden", act_low, 8'h62);
    prog_mode = 1'b1;
    fuse_wr = 1'b1; fuse_sel = 2'd2; fuse_wdata = 8'hFC;
    @(negedge clk);
    fuse_wr = 1'b0;
    chk("R3 load on entry", act_low, 8'h3C);
    chk("R11 entry write not loaded", act_ext, 8'hFF);
    fwrite(2'd0, 8'h11);
    chk("R4 prog write hidden", act_low, 8'h3C);
    prog_mode = 1'b0;
    @(negedge clk);
    chk("R4 no load on exit", act_low, 8'h3C);
    prog_mode = 1'b1;
    @(negedge clk);
    chk_act("R11 R3 re-entry load", 8'hFC, 8'h99, 8'h11);
  endtask

  task automatic t_eesave();
    fwrite(2'd1, 8'h80);
    chk("R5 eesave immediate", act_high, 8'h91);
    fwrite(2'd3, 8'h00);
    reenter();
    chk_act("R2 R5 sel3 ignored", 8'hFC, 8'h80, 8'h11);
  endtask

  task automatic t_locks();
    lwrite(8'hEF);
    chk("R8 lock write", lock_bits, 8'hEF);
    chk("R9 pair10 wr", {7'd0, boot_wr_deny}, 8'd1);
    chk("R9 pair10 rd", {7'd0, app_rd_deny}, 8'd0);
    ivec_in_app = 1'b1; exec_in_boot = 1'b1;
    #1;
    chk("R10 pair10 no mask", {7'd0, irq_mask}, 8'd0);
    lwrite(8'hFF);
    chk("R8 no 0 to 1", lock_bits, 8'hEF);
    lwrite(8'hDF);
    chk("R9 pair00", {6'd0, boot_wr_deny, app_rd_deny}, 8'd3);
    chk("R10 mask on", {7'd0, irq_mask}, 8'd1);
    exec_in_boot = 1'b0;
    #1;
    chk("R10 app code no mask", {7'd0, irq_mask}, 8'd0);
    exec_in_boot = 1'b1; ivec_in_app = 1'b0;
    #1;
    chk("R10 vec in boot no mask", {7'd0, irq_mask}, 8'd0);
    chip_erase = 1'b1; lock_wr = 1'b1; lock_wdata = 8'h00;
    @(negedge clk);
    chip_erase = 1'b0; lock_wr = 1'b0; lock_wdata = 8'hFF;
    chk("R6 R8 erase wins", lock_bits, 8'hFF);
    lwrite(8'hDF);
    chk("R9 pair01", {6'd0, boot_wr_deny, app_rd_deny}, 8'd1);
    ivec_in_app = 1'b1;
    #1;
    chk("R10 pair01 mask", {7'd0, irq_mask}, 8'd1);
    ivec_in_app = 1'b0; exec_in_boot = 1'b0;
  endtask

  task automatic t_guard();
    lwrite(8'hFE);
    fwrite(2'd0, 8'h00);
    fwrite(2'd1, 8'hFF);
    chk("R7 eesave blocked", act_high, 8'h80);
    reenter();
    chk_act("R7 writes ignored", 8'hFC, 8'h80, 8'h11);
    chip_erase = 1'b1;
    @(negedge clk);
    chip_erase = 1'b0;
    reenter();
    chk_act("R6 fuses kept", 8'hFC, 8'h80, 8'h11);
    fwrite(2'd0, 8'h55);
    reenter();
    chk("R7 unlocked by erase", act_low, 8'h55);
  endtask

  initial begin
    t_reset();
    t_capture();
    t_eesave();
    t_locks();
    t_guard();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule